// File: doc/BRIEF.md
# Performance-Monitor Register Access Trap Arbiter

This block decides the fate of a single access to a performance-monitor configuration register. It is purely combinational. The inputs are the privilege level that issues the access (0 to 3), whether the access reads or writes, and the control state of the surrounding levels:
- the 64-bit or 32-bit execution state of levels 1, 2 and 3;
- whether level 2 is active and whether level 3 is present;
- the user-access enable bit;
- the hypervisor's general-exception routing and host-extension bits;
- the hypervisor's instruction-group trap bit;
- the hypervisor and monitor monitor-unit trap bits;
- the monitor's fine-grained enable bit;
- separate fine-grained read and write trap bits.

From these the block produces exactly one verdict: the access completes, it traps to a named higher level, or it is undefined. With a trap it also gives the target level, the trap style and a six-bit syndrome class.

The checks follow a fixed priority chain, and the first one that hits wins. The user-enable gate at level 0 comes first. The hypervisor's checks follow, and the monitor's trap bit comes last. Host mode (host-extension and general-exception routing both set) removes some of the hypervisor's level-0 checks. The fine-grained check looks only at the trap bit that matches the access direction. The register storage sits outside this block.

Top module: `pmu_access_arbiter`

## Requirements
- R1: For every input combination exactly one of `allow`, `trap` and `undef` is 1.
- R2: An access from level 3 always completes.
- R3: An access from level 2 traps to level 3 only when level 3 is present, runs 64-bit and has its monitor trap bit set. Otherwise it completes.
- R4: At level 1 the hypervisor group trap (with level 2 active) is checked first and targets level 2. The hypervisor monitor trap follows and targets level 2. The monitor trap bit (level 3 present and 64-bit) comes last and targets level 3.
- R5: At level 0 with user access disabled and a 64-bit level 1, the access traps to level 2 when level 2 is active, runs 64-bit and has general-exception routing set. In every other case it traps to level 1.
- R6: At level 0 with user access disabled and a 32-bit level 1, the access traps to level 2 when level 2 is active and general-exception routing is set. In every other case it is undefined.
- R7: At level 0 with user access enabled, the group trap of a 64-bit hypervisor is skipped when host-extension and general-exception routing are both 1. The group trap of a 32-bit hypervisor is never skipped.
- R8: At level 0 the fine-grained trap targets level 2. It fires only when all of these hold: level 2 is active, level 1 is 64-bit, host mode is off, and level 3 is absent or its fine-grained enable is set. A read uses `fg_rd_trap` and a write uses `fg_wr_trap`.
- R9: At level 0 with user access enabled, the checks run in this order: group trap, fine-grained trap, hypervisor monitor trap, monitor trap. The access completes if none of them hits.
- R10: A trap reports `ec` = 0x03. The one exception is the R6 trap to a 32-bit level 2, which reports 0x00. When there is no trap, `ec` and `tgt_lvl` read 0.
- R11: `trap_style` is 2'b00 when there is no trap. It is 2'b10 (32-bit hypervisor trap) when the target is level 2 running 32-bit, and 2'b01 (64-bit system-access trap) for every other target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_lvl | input | 2 | Privilege level issuing the access |
| is_write | input | 1 | 1 for a write, 0 for a read |
| el1_is64 | input | 1 | Level 1 runs in 64-bit state |
| el2_is64 | input | 1 | Level 2 runs in 64-bit state |
| el3_is64 | input | 1 | Level 3 runs in 64-bit state |
| el2_active | input | 1 | Level 2 present and enabled in the current security state |
| el3_present | input | 1 | Level 3 is implemented |
| user_en | input | 1 | Level-0 access enable |
| tge | input | 1 | Hypervisor general-exception routing bit |
| e2h | input | 1 | Hypervisor host-extension bit |
| grp_trap | input | 1 | Hypervisor instruction-group trap bit |
| hyp_pmu_trap | input | 1 | Hypervisor monitor-unit trap bit |
| mon_pmu_trap | input | 1 | Level-3 monitor-unit trap bit |
| fg_enable | input | 1 | Level-3 fine-grained trap enable |
| fg_rd_trap | input | 1 | Fine-grained trap bit for reads |
| fg_wr_trap | input | 1 | Fine-grained trap bit for writes |
| allow | output | 1 | Access completes |
| trap | output | 1 | Access traps |
| undef | output | 1 | Access is undefined |
| tgt_lvl | output | 2 | Trap target level, 0 when no trap |
| trap_style | output | 2 | 00 none, 01 64-bit system-access trap, 10 32-bit hypervisor trap |
| ec | output | 6 | Syndrome class, 0 when no trap |

## Verification
Random vectors cover every level, with all control bits drawn independently. Trap bits that are set together show whether the design takes the right winner in each priority chain, not just any trap. Directed vectors cover the points where the answer changes:
- the user-disabled gate with each pairing of level-1 and level-2 execution states, which separates the level-1 trap, the two level-2 trap styles and the undefined result;
- host mode with each hypervisor width, which shows whether the skip reaches only the checks it should;
- the fine-grained bits set opposite to the access direction, which shows whether the design swaps read and write;
- level 3 present without fine-grained enable, which shows whether the enable gate is honoured.

// File: rtl/pmu_trap_pkg.sv
package pmu_trap_pkg;

  localparam int LVL_W   = 2;
  localparam int EC_W    = 6;
  localparam int STYLE_W = 2;

  localparam logic [EC_W-1:0] EC_SYS_ACCESS = 6'h03;
  localparam logic [EC_W-1:0] EC_UNKNOWN    = 6'h00;

  typedef enum logic [LVL_W-1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2,
    LVL3 = 2'd3
  } lvl_e;

  typedef enum logic [STYLE_W-1:0] {
    STY_NONE  = 2'b00,
    STY_SYS64 = 2'b01,
    STY_HYP32 = 2'b10
  } style_e;

  // Trap style follows the execution state of the level that takes the trap.
  function automatic style_e style_for(input lvl_e tgt, input logic el2_64);
    if (tgt == LVL2 && !el2_64) return STY_HYP32;
    return STY_SYS64;
  endfunction

  // Host mode: host-extension and general-exception routing both on.
  function automatic logic host_mode(input logic e2h_b, input logic tge_b);
    return e2h_b & tge_b;
  endfunction

endpackage

// File: rtl/pmu_user_gate.sv
// Level-0 user-enable gate: verdict when user access is disabled.
module pmu_user_gate
  import pmu_trap_pkg::*;
#(
  parameter int EC_WIDTH = EC_W
) (
  input  logic                from_user,
  input  logic                user_en,
  input  logic                el1_is64,
  input  logic                el2_active,
  input  logic                el2_is64,
  input  logic                tge,
  output logic                blk_hit,
  output logic                blk_undef,
  output lvl_e                blk_tgt,
  output logic [EC_WIDTH-1:0] blk_ec
);

  logic route_hyp64;
  logic route_hyp32;

  assign route_hyp64 = el2_active & el2_is64 & tge;
  assign route_hyp32 = el2_active & ~el2_is64 & tge;
  assign blk_hit     = from_user & ~user_en;

  always_comb begin
    blk_undef = 1'b0;
    blk_tgt   = LVL0;
    blk_ec    = EC_WIDTH'(EC_SYS_ACCESS);
    if (route_hyp64) begin
      blk_tgt = LVL2;
    end else if (el1_is64) begin
      blk_tgt = LVL1;
    end else if (route_hyp32) begin
      blk_tgt = LVL2;
      blk_ec  = EC_WIDTH'(EC_UNKNOWN);
    end else begin
      blk_undef = 1'b1;
      blk_ec    = '0;
    end
  end

endmodule

// File: rtl/pmu_hyp_checks.sv
// Hypervisor-owned trap sources: group, fine-grained and monitor-unit bits.
module pmu_hyp_checks
  import pmu_trap_pkg::*;
(
  input  logic from_user,
  input  logic is_write,
  input  logic el1_is64,
  input  logic el2_active,
  input  logic el2_is64,
  input  logic el3_present,
  input  logic e2h,
  input  logic tge,
  input  logic grp_trap,
  input  logic hyp_pmu_trap,
  input  logic fg_enable,
  input  logic fg_rd_trap,
  input  logic fg_wr_trap,
  output logic grp_hit,
  output logic fg_hit,
  output logic pmu_hit
);

  logic host_on;
  logic grp_skip;
  logic fg_bit;
  logic fg_gate;

  assign host_on  = host_mode(e2h, tge);
  // Host mode hides the group trap only for a 64-bit hypervisor.
  assign grp_skip = from_user & el2_is64 & host_on;
  assign grp_hit  = el2_active & grp_trap & ~grp_skip;

  assign fg_bit   = is_write ? fg_wr_trap : fg_rd_trap;
  assign fg_gate  = from_user & el2_active & el1_is64 & ~host_on
                  & (~el3_present | fg_enable);
  assign fg_hit   = fg_gate & fg_bit;

  assign pmu_hit  = el2_active & hyp_pmu_trap;

endmodule

// File: rtl/pmu_mon_check.sv
// Level-3 monitor-unit trap source.
module pmu_mon_check (
  input  logic el3_present,
  input  logic el3_is64,
  input  logic mon_pmu_trap,
  output logic mon_hit
);

  assign mon_hit = el3_present & el3_is64 & mon_pmu_trap;

endmodule

// File: rtl/pmu_access_arbiter.sv
module pmu_access_arbiter
  import pmu_trap_pkg::*;
#(
  parameter int EC_WIDTH = EC_W
) (
  input  logic [LVL_W-1:0]   cur_lvl,
  input  logic               is_write,
  input  logic               el1_is64,
  input  logic               el2_is64,
  input  logic               el3_is64,
  input  logic               el2_active,
  input  logic               el3_present,
  input  logic               user_en,
  input  logic               tge,
  input  logic               e2h,
  input  logic               grp_trap,
  input  logic               hyp_pmu_trap,
  input  logic               mon_pmu_trap,
  input  logic               fg_enable,
  input  logic               fg_rd_trap,
  input  logic               fg_wr_trap,
  output logic               allow,
  output logic               trap,
  output logic               undef,
  output logic [LVL_W-1:0]   tgt_lvl,
  output logic [STYLE_W-1:0] trap_style,
  output logic [EC_WIDTH-1:0] ec
);

  lvl_e                lvl;
  logic                from_user;
  logic                w_user_blk;
  logic                w_user_undef;
  lvl_e                w_user_tgt;
  logic [EC_WIDTH-1:0] w_user_ec;
  logic                w_grp_hit;
  logic                w_fg_hit;
  logic                w_hyp_pmu_hit;
  logic                w_mon_hit;
  lvl_e                tgt_q;
  logic [EC_WIDTH-1:0] ec_q;

  assign lvl       = lvl_e'(cur_lvl);
  assign from_user = (lvl == LVL0);

  pmu_user_gate #(.EC_WIDTH(EC_WIDTH)) u_gate (
    .from_user (from_user),
    .user_en   (user_en),
    .el1_is64  (el1_is64),
    .el2_active(el2_active),
    .el2_is64  (el2_is64),
    .tge       (tge),
    .blk_hit   (w_user_blk),
    .blk_undef (w_user_undef),
    .blk_tgt   (w_user_tgt),
    .blk_ec    (w_user_ec)
  );

  pmu_hyp_checks u_hyp (
    .from_user   (from_user),
    .is_write    (is_write),
    .el1_is64    (el1_is64),
    .el2_active  (el2_active),
    .el2_is64    (el2_is64),
    .el3_present (el3_present),
    .e2h         (e2h),
    .tge         (tge),
    .grp_trap    (grp_trap),
    .hyp_pmu_trap(hyp_pmu_trap),
    .fg_enable   (fg_enable),
    .fg_rd_trap  (fg_rd_trap),
    .fg_wr_trap  (fg_wr_trap),
    .grp_hit     (w_grp_hit),
    .fg_hit      (w_fg_hit),
    .pmu_hit     (w_hyp_pmu_hit)
  );

  pmu_mon_check u_mon (
    .el3_present (el3_present),
    .el3_is64    (el3_is64),
    .mon_pmu_trap(mon_pmu_trap),
    .mon_hit     (w_mon_hit)
  );

  // Priority resolution per issuing level; first hit wins.
  always_comb begin
    allow = 1'b0;
    trap  = 1'b0;
    undef = 1'b0;
    tgt_q = LVL0;
    ec_q  = EC_WIDTH'(EC_SYS_ACCESS);
    unique case (lvl)
      LVL3: allow = 1'b1;
      LVL2: begin
        if (w_mon_hit) begin trap = 1'b1; tgt_q = LVL3; end
        else allow = 1'b1;
      end
      LVL1: begin
        if (w_grp_hit || w_hyp_pmu_hit) begin trap = 1'b1; tgt_q = LVL2; end
        else if (w_mon_hit)             begin trap = 1'b1; tgt_q = LVL3; end
        else allow = 1'b1;
      end
      default: begin
        if (w_user_blk) begin
          undef = w_user_undef;
          trap  = ~w_user_undef;
          tgt_q = w_user_tgt;
          ec_q  = w_user_ec;
        end else if (w_grp_hit || w_fg_hit || w_hyp_pmu_hit) begin
          trap = 1'b1; tgt_q = LVL2;
        end else if (w_mon_hit) begin
          trap = 1'b1; tgt_q = LVL3;
        end else allow = 1'b1;
      end
    endcase
  end

  assign tgt_lvl    = trap ? tgt_q : LVL0;
  assign ec         = trap ? ec_q : '0;
  assign trap_style = trap ? style_for(tgt_q, el2_is64) : STY_NONE;

endmodule

// File: rtl/pmu_access_arbiter_chk.sv
module pmu_access_arbiter_chk (
  input logic [1:0] cur_lvl,
  input logic       is_write,
  input logic       el1_is64,
  input logic       el2_is64,
  input logic       el3_is64,
  input logic       el2_active,
  input logic       el3_present,
  input logic       user_en,
  input logic       tge,
  input logic       e2h,
  input logic       grp_trap,
  input logic       hyp_pmu_trap,
  input logic       mon_pmu_trap,
  input logic       fg_rd_trap,
  input logic       fg_wr_trap,
  input logic       allow,
  input logic       trap,
  input logic       undef,
  input logic [1:0] tgt_lvl,
  input logic [1:0] trap_style,
  input logic [5:0] ec,
  input logic       w_grp_hit,
  input logic       w_fg_hit
);

  always_comb begin
    // R1
    one_verdict_chk: assert ($countones({allow, trap, undef}) == 1)
      else $error("verdict not one-hot");
    // R2
    top_level_allow_chk: assert (cur_lvl != 2'd3 || allow)
      else $error("level 3 access blocked");
    // R3
    lvl2_monitor_only_chk: assert (cur_lvl != 2'd2 ||
        (trap == (el3_present && el3_is64 && mon_pmu_trap)))
      else $error("level 2 verdict wrong");
    // R4
    lvl1_group_first_chk: assert (!(cur_lvl == 2'd1 && w_grp_hit) ||
        (trap && tgt_lvl == 2'd2))
      else $error("level 1 group trap lost");
    // R6
    undef_source_chk: assert (!undef || (cur_lvl == 2'd0 && !user_en && !el1_is64))
      else $error("undefined from wrong state");
    // R7
    host_skip_chk: assert (!(cur_lvl == 2'd0 && user_en && el2_is64 && e2h && tge &&
        !hyp_pmu_trap && !mon_pmu_trap) || allow)
      else $error("host mode did not skip");
    // R8
    fg_direction_chk: assert (!w_fg_hit || (el1_is64 && (is_write ? fg_wr_trap : fg_rd_trap)))
      else $error("fine-grained bit mismatch");
    // R10
    ec_zero_case_chk: assert (!(trap && ec == 6'h00) ||
        (cur_lvl == 2'd0 && !user_en && tgt_lvl == 2'd2 && !el2_is64))
      else $error("syndrome 0 outside its case");
    // R11
    style_idle_chk: assert (trap || (trap_style == 2'b00 && ec == 6'h00 && tgt_lvl == 2'd0))
      else $error("trap fields set without trap");
    // R11
    style_sys_chk: assert (!(trap && (tgt_lvl != 2'd2 || el2_is64)) || trap_style == 2'b01)
      else $error("style wrong for 64-bit target");
  end

endmodule

bind pmu_access_arbiter pmu_access_arbiter_chk u_chk (
  .cur_lvl     (cur_lvl),
  .is_write    (is_write),
  .el1_is64    (el1_is64),
  .el2_is64    (el2_is64),
  .el3_is64    (el3_is64),
  .el2_active  (el2_active),
  .el3_present (el3_present),
  .user_en     (user_en),
  .tge         (tge),
  .e2h         (e2h),
  .grp_trap    (grp_trap),
  .hyp_pmu_trap(hyp_pmu_trap),
  .mon_pmu_trap(mon_pmu_trap),
  .fg_rd_trap  (fg_rd_trap),
  .fg_wr_trap  (fg_wr_trap),
  .allow       (allow),
  .trap        (trap),
  .undef       (undef),
  .tgt_lvl     (tgt_lvl),
  .trap_style  (trap_style),
  .ec          (ec),
  .w_grp_hit   (w_grp_hit),
  .w_fg_hit    (w_fg_hit)
);

// File: tb/tb_pmu_access_arbiter.sv
module tb_pmu_access_arbiter;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] cur_lvl;
  logic is_write, el1_is64, el2_is64, el3_is64, el2_active, el3_present;
  logic user_en, tge, e2h, grp_trap, hyp_pmu_trap, mon_pmu_trap;
  logic fg_enable, fg_rd_trap, fg_wr_trap;
  logic allow, trap, undef;
  logic [1:0] tgt_lvl, trap_style;
  logic [5:0] ec;

  pmu_access_arbiter dut (
    .cur_lvl(cur_lvl), .is_write(is_write), .el1_is64(el1_is64),
    .el2_is64(el2_is64), .el3_is64(el3_is64), .el2_active(el2_active),
    .el3_present(el3_present), .user_en(user_en), .tge(tge), .e2h(e2h),
    .grp_trap(grp_trap), .hyp_pmu_trap(hyp_pmu_trap), .mon_pmu_trap(mon_pmu_trap),
    .fg_enable(fg_enable), .fg_rd_trap(fg_rd_trap), .fg_wr_trap(fg_wr_trap),
    .allow(allow), .trap(trap), .undef(undef), .tgt_lvl(tgt_lvl),
    .trap_style(trap_style), .ec(ec)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Expected results
  logic [2:0] x_flags;   // {allow, trap, undef}
  logic [1:0] x_tgt;
  logic [1:0] x_style;
  logic [5:0] x_ec;
  string      x_tag;

  function automatic void give_trap(input logic [1:0] t, input logic [5:0] code);
    x_flags = 3'b010;
    x_tgt   = t;
    x_ec    = code;
    x_style = (t == 2'd2 && !el2_is64) ? 2'b10 : 2'b01;
  endfunction

  function automatic void predict();
    logic hyp64, hyp32, mon3, host;
    hyp64 = el2_active && el2_is64;
    hyp32 = el2_active && !el2_is64;
    mon3  = el3_present && el3_is64 && mon_pmu_trap;
    host  = e2h && tge;
    x_flags = 3'b100; x_tgt = 2'd0; x_style = 2'b00; x_ec = 6'h00;
    case (cur_lvl)
      2'd3: x_tag = "R2";
      2'd2: begin
        x_tag = "R3";
        if (mon3) give_trap(2'd3, 6'h03);
      end
      2'd1: begin
        x_tag = "R4";
        if (el2_active && grp_trap)          give_trap(2'd2, 6'h03);
        else if (el2_active && hyp_pmu_trap) give_trap(2'd2, 6'h03);
        else if (mon3)                       give_trap(2'd3, 6'h03);
      end
      default: begin
        if (!user_en) begin
          x_tag = el1_is64 ? "R5" : "R6";
          if (hyp64 && tge)       give_trap(2'd2, 6'h03);
          else if (el1_is64)      give_trap(2'd1, 6'h03);
          else if (hyp32 && tge)  give_trap(2'd2, 6'h00);
          else x_flags = 3'b001;
        end else begin
          x_tag = "R9";
          if (hyp64 && !host && grp_trap) begin x_tag = "R7"; give_trap(2'd2, 6'h03); end
          else if (hyp32 && grp_trap)      begin x_tag = "R7"; give_trap(2'd2, 6'h03); end
          else if (el2_active && el1_is64 && !host && (!el3_present || fg_enable) &&
                   (is_write ? fg_wr_trap : fg_rd_trap)) begin
            x_tag = "R8"; give_trap(2'd2, 6'h03);
          end
          else if (el2_active && hyp_pmu_trap) give_trap(2'd2, 6'h03);
          else if (mon3)                       give_trap(2'd3, 6'h03);
        end
      end
    endcase
  endfunction

  task automatic check_now(input string label);
    predict();
    checks++;
    if ({allow, trap, undef} != x_flags) begin
      failures++;
      $display("FAIL %s %s verdict got=%b exp=%b", label, x_tag, {allow, trap, undef}, x_flags);
    end
    checks++;
    if ($countones({allow, trap, undef}) != 1) begin
      failures++;
      $display("FAIL %s R1 one-hot got=%b exp=one bit", label, {allow, trap, undef});
    end
    checks++;
    if (tgt_lvl != x_tgt || ec != x_ec) begin
      failures++;
      $display("FAIL %s %s/R10 tgt=%0d ec=%h exp tgt=%0d ec=%h",
               label, x_tag, tgt_lvl, ec, x_tgt, x_ec);
    end
    checks++;
    if (trap_style != x_style) begin
      failures++;
      $display("FAIL %s R11 style got=%b exp=%b", label, trap_style, x_style);
    end
  endtask

  task automatic clear_all();
    {cur_lvl, is_write, el1_is64, el2_is64, el3_is64, el2_active, el3_present} = '0;
    {user_en, tge, e2h, grp_trap, hyp_pmu_trap, mon_pmu_trap} = '0;
    {fg_enable, fg_rd_trap, fg_wr_trap} = '0;
  endtask

  task automatic settle_and_check(input string label);
    @(posedge clk);
    #2;
    check_now(label);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clear_all();
    @(negedge clk);
    // Quiet state: level 0, user disabled, 32-bit level 1 -> undefined (R6)
    settle_and_check("idle_R6");

    // R6: 32-bit hypervisor with routing -> level-2 32-bit trap, syndrome 0
    el2_active = 1; tge = 1;
    settle_and_check("hyp32_route_R6_R10");
    // R6: 64-bit hypervisor with routing
    el2_is64 = 1;
    settle_and_check("hyp64_route_R6");
    // R5: 64-bit level 1, 32-bit hypervisor with routing -> level 1
    el1_is64 = 1; el2_is64 = 0;
    settle_and_check("l1_64_R5");
    // R5: 64-bit hypervisor with routing -> level 2
    el2_is64 = 1;
    settle_and_check("hyp64_R5");

    // R7: host mode hides 64-bit group trap
    clear_all(); user_en = 1; el1_is64 = 1; el2_active = 1; el2_is64 = 1;
    e2h = 1; tge = 1; grp_trap = 1;
    settle_and_check("host_skip_R7");
    // R7: 32-bit hypervisor group trap not skipped
    el2_is64 = 0;
    settle_and_check("host_noskip32_R7");

    // R8: write trap bit only, read access -> completes; write -> traps
    clear_all(); user_en = 1; el1_is64 = 1; el2_active = 1; el2_is64 = 1;
    fg_wr_trap = 1;
    settle_and_check("fg_read_R8");
    is_write = 1;
    settle_and_check("fg_write_R8");
    // R8: level 3 present, fine-grained disabled -> completes
    el3_present = 1; el3_is64 = 1;
    settle_and_check("fg_gated_R8");
    fg_enable = 1;
    settle_and_check("fg_enabled_R8");

    // R4: group and monitor both set at level 1 -> level 2 wins
    clear_all(); cur_lvl = 2'd1; el2_active = 1; el2_is64 = 1; grp_trap = 1;
    el3_present = 1; el3_is64 = 1; mon_pmu_trap = 1;
    settle_and_check("l1_prio_R4");
    grp_trap = 0;
    settle_and_check("l1_mon_R4");

    // R3: 32-bit level 3 ignores its trap bit
    cur_lvl = 2'd2; el3_is64 = 0;
    settle_and_check("l2_mon32_R3");
    el3_is64 = 1;
    settle_and_check("l2_mon64_R3");

    // R2: level 3 with every trap set
    {is_write, el1_is64, el2_is64, el3_is64, el2_active, el3_present} = '1;
    {tge, e2h, grp_trap, hyp_pmu_trap, mon_pmu_trap, fg_enable, fg_rd_trap, fg_wr_trap} = '1;
    user_en = 0; cur_lvl = 2'd3;
    settle_and_check("l3_all_R2");

    // Random sweep, all levels
    for (int i = 0; i < 4000; i++) begin
      cur_lvl      = 2'($urandom_range(0, 3));
      is_write     = 1'($urandom);
      el1_is64     = 1'($urandom);
      el2_is64     = 1'($urandom);
      el3_is64     = 1'($urandom);
      el2_active   = 1'($urandom);
      el3_present  = 1'($urandom);
      user_en      = ($urandom_range(0, 3) != 0);
      tge          = 1'($urandom);
      e2h          = 1'($urandom);
      grp_trap     = ($urandom_range(0, 2) == 0);
      hyp_pmu_trap = ($urandom_range(0, 2) == 0);
      mon_pmu_trap = 1'($urandom);
      fg_enable    = 1'($urandom);
      fg_rd_trap   = 1'($urandom);
      fg_wr_trap   = 1'($urandom);
      settle_and_check("random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule